// File: doc/BRIEF.md
# Phase-Error Lock Monitor

This block watches a reference clock and the divided feedback clock of a digital PLL. Both are sampled by a fast system clock. It measures how many system-clock ticks separate matching rising edges, and it compares that count with a threshold `thresh_m`. One tick is the unit delay, so the threshold is M ticks. A small M gives a tight phase tolerance, and a large M gives a loose one. The same detector therefore covers both a relaxed video clock and a demanding display clock.

When the error is within the threshold, the block reports lock, and fine phase correction is left to the normal loop. When the error exceeds the threshold in either direction, the block clears the lock flag and issues one `cycle_sync` pulse to start the fast-lock engine. The pulse lasts exactly one reference period. A second pulse is only possible after the loop has again been judged within the threshold. A missing feedback edge counts as an over-threshold error.

Top module: `phase_lock_monitor`

## Requirements
- R1: While reset is held, and after reset releases before any judgement, `locked`, `fb_leads` and `cycle_sync` are all 0.
- R2: The error is the number of system-clock ticks between the synchronised reference rising edge and the paired feedback rising edge. `locked` becomes 1 after a judgement whose error is at most `thresh_m`.
- R3: While every judgement stays within the threshold, `cycle_sync` never rises.
- R4: After a judgement, `fb_leads` is 1 if the feedback edge came before the reference edge. It is 0 if the feedback edge came after the reference edge or in the same tick.
- R5: An error exactly equal to `thresh_m` counts as within the threshold.
- R6: An error greater than `thresh_m`, with the feedback edge either leading or lagging, clears `locked`.
- R7: After an over-threshold judgement while armed, `cycle_sync` rises in the cycle after the next detected reference edge. It stays high for exactly one reference period, which is 40 ticks when the reference period is 40 ticks.
- R8: A sustained over-threshold condition yields only one `cycle_sync` pulse. The pulse re-arms only after a judgement within the threshold.
- R9: A reference edge with no feedback edge within half of the measured reference period is judged over threshold. It clears `locked` and triggers `cycle_sync`.
- R10: With `thresh_m` = 0, only coincident edges count as locked, and an error of one tick unlocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples both inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| thresh_m | input | TW | Threshold in ticks (M) |
| locked | output | 1 | Last judgement was within the threshold |
| fb_leads | output | 1 | Feedback edge preceded the reference edge in the last judgement |
| cycle_sync | output | 1 | Fast-lock start pulse, one reference period wide |

## Verification
Each input edge takes three ticks to be detected: two for the synchroniser and one for edge detection. `locked` and `fb_leads` change one tick after the closing edge is detected. `cycle_sync` rises one tick after the reference edge that follows an over-threshold judgement, and it falls one tick after the next reference edge.

The bench drives both clocks tick by tick on the falling system-clock edge, with a 40-tick reference period and a chosen feedback offset. It reads the flags only after several reference periods, when they are settled. It counts `cycle_sync` rises per phase and measures each pulse width in ticks, so none of the results depends on the exact tick in which an output changes.

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int TW = 8,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic [TW-1:0] thresh_m,
  output logic          locked,
  output logic          fb_leads,
  output logic          cycle_sync
);

  logic [2:0]    ref_s, fb_s;
  logic          waiting, fb_first, armed, pending, per_ok;
  logic [CW-1:0] cnt, per_cnt, per_len;

  wire ref_rise = ref_s[1] & ~ref_s[2];
  wire fb_rise  = fb_s[1] & ~fb_s[2];

  wire [CW-1:0] half = per_len >> 1;
  wire other  = fb_first ? ref_rise : fb_rise;
  wire both   = !waiting && ref_rise && fb_rise;
  wire closed = waiting && other;
  wire tmo    = waiting && !other && (half != '0) && (cnt >= half);
  wire judge  = closed || tmo || both;
  wire [CW-1:0] err = both ? '0 : cnt;
  wire over   = tmo || (err > CW'(thresh_m));
  wire trig   = judge && over && armed;
  wire fire   = ref_rise && !cycle_sync && (pending || trig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_s <= '0;
      fb_s  <= '0;
    end else begin
      ref_s <= {ref_s[1:0], ref_in};
      fb_s  <= {fb_s[1:0], fb_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      fb_first <= 1'b0;
      cnt      <= '0;
    end else if (!waiting) begin
      if ((ref_rise || fb_rise) && !both) begin
        waiting  <= 1'b1;
        fb_first <= fb_rise;
        cnt      <= CW'(1);
      end
    end else if (judge) begin
      waiting <= 1'b0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
      per_len <= '0;
      per_ok  <= 1'b0;
    end else if (ref_rise) begin
      per_cnt <= CW'(1);
      per_ok  <= 1'b1;
      if (per_ok) per_len <= per_cnt;
    end else if (per_cnt != '1) begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      fb_leads   <= 1'b0;
      armed      <= 1'b1;
      pending    <= 1'b0;
      cycle_sync <= 1'b0;
    end else begin
      if (judge) begin
        locked   <= !over;
        fb_leads <= both ? 1'b0 : fb_first;
      end
      if (judge && !over) armed <= 1'b1;
      else if (trig)      armed <= 1'b0;
      if (fire)           pending <= 1'b0;
      else if (trig)      pending <= 1'b1;
      if (ref_rise)       cycle_sync <= fire;
    end
  end

  assert_lock_within_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (judge && !over) |=> locked);
  assert_unlock_over_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (judge && over) |=> !locked);
  assert_sync_starts_on_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycle_sync) |-> $past(ref_rise));
  assert_sync_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_sync && !ref_rise) |=> cycle_sync);
  assert_sync_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_sync && ref_rise) |=> !cycle_sync);
  assert_timeout_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !locked);

endmodule

// File: tb/phase_lock_monitor_tb.sv
module phase_lock_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic [7:0] thresh_m = 8'd4;
  logic       locked, fb_leads, cycle_sync;

  int checks = 0, fails = 0;
  int pulses = 0, cur_w = 0, last_w = 0;
  bit prev_sync = 1'b0;

  always #10 clk = ~clk;

  phase_lock_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .thresh_m(thresh_m), .locked(locked), .fb_leads(fb_leads),
    .cycle_sync(cycle_sync)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    repeat (5) @(negedge clk);
    check(locked == 0 && fb_leads == 0 && cycle_sync == 0, "R1 reset outputs",
          {locked, fb_leads, cycle_sync}, 0);
    rst_n = 1'b1;
    pulses = 0; cur_w = 0; last_w = 0; prev_sync = 1'b0;
  endtask

  task automatic run(input int ncyc, input int off, input bit fb_on);
    pulses = 0;
    for (int c = 0; c < ncyc; c++) begin
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (cycle_sync && !prev_sync) pulses++;
        if (cycle_sync) cur_w++;
        else if (prev_sync) begin last_w = cur_w; cur_w = 0; end
        prev_sync = cycle_sync;
        ref_in = (t < 20);
        fb_in  = fb_on && ((((t - off) % 40) + 40) % 40 < 20);
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(locked == 0 && cycle_sync == 0 && fb_leads == 0, "R1 idle after reset",
          {locked, fb_leads, cycle_sync}, 0);
  endtask

  task automatic t_lag_lock();
    do_reset(); thresh_m = 4; run(6, 3, 1'b1);
    check(locked == 1, "R2 lag 3 within M=4", locked, 1);
    check(fb_leads == 0, "R4 lagging feedback", fb_leads, 0);
    check(pulses == 0, "R3 no trigger while within", pulses, 0);
  endtask

  task automatic t_lead_lock();
    do_reset(); thresh_m = 4; run(6, -3, 1'b1);
    check(locked == 1, "R2 lead 3 within M=4", locked, 1);
    check(fb_leads == 1, "R4 leading feedback", fb_leads, 1);
    do_reset(); run(6, 0, 1'b1);
    check(fb_leads == 0, "R4 coincident edges", fb_leads, 0);
    check(locked == 1, "R2 zero error", locked, 1);
  endtask

  task automatic t_boundary();
    do_reset(); thresh_m = 4; run(6, 4, 1'b1);
    check(locked == 1, "R5 error equal to M", locked, 1);
    check(pulses == 0, "R5 no trigger at M", pulses, 0);
    do_reset(); run(6, 5, 1'b1);
    check(locked == 0, "R6 error M+1 lagging", locked, 0);
    check(pulses == 1, "R7 one pulse on unlock", pulses, 1);
    check(last_w == 40, "R7 pulse width one ref period", last_w, 40);
  endtask

  task automatic t_rearm();
    do_reset(); thresh_m = 4; run(6, 8, 1'b1);
    check(pulses == 1, "R8 single pulse for sustained error", pulses, 1);
    run(4, 0, 1'b1);
    check(locked == 1, "R8 relock", locked, 1);
    check(pulses == 0, "R8 no pulse while relocking", pulses, 0);
    run(6, 8, 1'b1);
    check(pulses == 1, "R8 re-armed pulse", pulses, 1);
    check(last_w == 40, "R7 re-armed pulse width", last_w, 40);
  endtask

  task automatic t_lead_over();
    do_reset(); thresh_m = 4; run(6, -8, 1'b1);
    check(locked == 0, "R6 error over M leading", locked, 0);
    check(fb_leads == 1, "R4 leading over threshold", fb_leads, 1);
    check(pulses == 1, "R7 pulse on leading unlock", pulses, 1);
  endtask

  task automatic t_scale();
    do_reset(); thresh_m = 10; run(6, 8, 1'b1);
    check(locked == 1, "R2 loose M=10 accepts 8", locked, 1);
    do_reset(); thresh_m = 0; run(6, 0, 1'b1);
    check(locked == 1, "R10 M=0 coincident", locked, 1);
    do_reset(); run(6, 1, 1'b1);
    check(locked == 0, "R10 M=0 one tick", locked, 0);
    thresh_m = 4;
  endtask

  task automatic t_timeout();
    do_reset(); thresh_m = 4; run(6, 0, 1'b0);
    check(locked == 0, "R9 missing feedback unlocks", locked, 0);
    check(pulses == 1, "R9 missing feedback triggers", pulses, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lag_lock();
    t_lead_lock();
    t_boundary();
    t_rearm();
    t_lead_over();
    t_scale();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule